// File: doc/BRIEF.md
# Line-Paced Audio Ring Reader

This block drains stereo audio from a circular buffer held in shared memory, producing samples at a fixed output rate. The rate comes from the video scan-line timing and the audio clock-regeneration pair N and CTS, so no resampling is needed. A signed phase accumulator is incremented by a precomputed per-line constant once per scan-line strobe. Each sample taken from the ring decrements the accumulator by a second precomputed constant. Reading stops once the accumulator goes negative, or once two samples have been taken on that line.

Every word taken from the ring is overwritten with zero. If the producer stalls, the buffer therefore fades to silence instead of replaying stale audio. After each word, the read pointer moves on one word, or returns to the start address when it sits on the limit address. The new pointer is published on a port and also written to a fixed memory location, so a producer can keep its own head pointer ahead of it. Each channel is scaled by its own volume factor and handed to a packet builder over a valid/ready handshake.

Top module: `line_audio_fifo`

## Requirements
- R1: After reset, `out_valid` and `mem_req` are low and `tail_ptr` equals `cfg_start`.
- R2: Each `line_stb` accepted while idle adds `cfg_line_inc` to a signed accumulator that starts at zero. While the accumulator is non-negative, one word is read and `cfg_sample_dec` is subtracted from it, and the test is repeated.
- R3: No more than two words are read per scan line. Any positive residue left in the accumulator carries over to the next line.
- R4: A buffer word holds the left channel in bits 31:16 and the right channel in bits 15:0, both two's-complement 16-bit values.
- R5: In the cycle after a read is issued, zero is written to the same address.
- R6: After a read, the pointer becomes `cfg_start` if it equalled `cfg_limit`, and otherwise increments by one word address.
- R7: After each zero write, the updated pointer (zero-extended to 32 bits) is written to `cfg_tail_addr`. `tail_ptr` carries the same value.
- R8: Each output channel equals the signed sample multiplied by the unsigned volume (256 means unity), arithmetically shifted right by 8. The result is `VOL_W+9` bits wide and is not truncated.
- R9: While `out_valid` is high and `out_ready` is low, the output data is held stable and no memory access is made.
- R10: Configuration inputs are captured only while the block is idle. A change made while samples of a line are still pending does not alter those samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per scan line |
| cfg_start | input | AW | First word address of the ring |
| cfg_limit | input | AW | Last word address of the ring |
| cfg_tail_addr | input | AW | Address that receives the published pointer |
| cfg_line_inc | input | ACC_W | Per-line accumulator increment (pixels times N) |
| cfg_sample_dec | input | ACC_W | Per-sample decrement (128 times CTS) |
| cfg_vol_l | input | VOL_W | Left volume, 256 = unity |
| cfg_vol_r | input | VOL_W | Right volume, 256 = unity |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tail_ptr | output | AW | Current read pointer |
| out_valid | output | 1 | Scaled sample available |
| out_ready | input | 1 | Consumer accepts sample |
| out_left | output | VOL_W+9 | Scaled left sample |
| out_right | output | VOL_W+9 | Scaled right sample |

## Verification
The assertions assume that `line_stb` arrives only while the block is idle. They also assume that `cfg_start` and `cfg_limit` stay constant after reset, and that memory returns read data one cycle after the request. The bench holds the ring bounds and the tail address fixed for the whole run. It leaves thirty cycles between strobes, which is far longer than two samples take to drain. It answers every read request with one-cycle latency. Only the volume and pacing constants change during a run, and the volume changes while a line is pending are made deliberately to exercise R10.

// File: rtl/line_audio_fifo.sv
module line_audio_fifo #(
  parameter int AW    = 16,
  parameter int ACC_W = 32,
  parameter int VOL_W = 9,
  parameter int MAX_PER_LINE = 2,
  localparam int OUT_W = VOL_W + 9,
  localparam int PW    = VOL_W + 17,
  localparam int CW    = $clog2(MAX_PER_LINE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic [AW-1:0]    cfg_start,
  input  logic [AW-1:0]    cfg_limit,
  input  logic [AW-1:0]    cfg_tail_addr,
  input  logic [ACC_W-1:0] cfg_line_inc,
  input  logic [ACC_W-1:0] cfg_sample_dec,
  input  logic [VOL_W-1:0] cfg_vol_l,
  input  logic [VOL_W-1:0] cfg_vol_r,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [AW-1:0]    tail_ptr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_READ, S_CLEAR, S_TAIL, S_OUT} state_t;

  state_t            state;
  logic [ACC_W-1:0]  acc;
  logic [AW-1:0]     ptr, start_q, limit_q, tail_q;
  logic [ACC_W-1:0]  dec_q;
  logic [VOL_W-1:0]  vol_l_q, vol_r_q;
  logic [CW-1:0]     cnt;
  logic [31:0]       word;
  logic signed [PW-1:0] prod_l, prod_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      acc     <= '0;
      ptr     <= cfg_start;
      start_q <= cfg_start;
      limit_q <= cfg_limit;
      tail_q  <= cfg_tail_addr;
      dec_q   <= cfg_sample_dec;
      vol_l_q <= cfg_vol_l;
      vol_r_q <= cfg_vol_r;
      cnt     <= '0;
      word    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          start_q <= cfg_start;
          limit_q <= cfg_limit;
          tail_q  <= cfg_tail_addr;
          dec_q   <= cfg_sample_dec;
          vol_l_q <= cfg_vol_l;
          vol_r_q <= cfg_vol_r;
          if (line_stb) begin
            acc   <= acc + cfg_line_inc;
            cnt   <= '0;
            state <= S_CHECK;
          end
        end
        S_CHECK: state <= (!acc[ACC_W-1] && cnt < CW'(MAX_PER_LINE)) ? S_READ : S_IDLE;
        S_READ:  state <= S_CLEAR;
        S_CLEAR: begin
          word  <= mem_rdata;
          acc   <= acc - dec_q;
          ptr   <= (ptr == limit_q) ? start_q : ptr + AW'(1);
          cnt   <= cnt + CW'(1);
          state <= S_TAIL;
        end
        S_TAIL:  state <= S_OUT;
        S_OUT:   if (out_ready) state <= S_CHECK;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == S_READ) || (state == S_CLEAR) || (state == S_TAIL);
  assign mem_we    = (state == S_CLEAR) || (state == S_TAIL);
  assign mem_addr  = (state == S_TAIL) ? tail_q : ptr;
  assign mem_wdata = (state == S_TAIL) ? {{(32-AW){1'b0}}, ptr} : 32'd0;
  assign tail_ptr  = ptr;
  assign out_valid = (state == S_OUT);

  assign prod_l = $signed({{(VOL_W+1){word[31]}}, word[31:16]}) * $signed({16'd0, 1'b0, vol_l_q});
  assign prod_r = $signed({{(VOL_W+1){word[15]}}, word[15:0]})  * $signed({16'd0, 1'b0, vol_r_q});
  assign out_left  = prod_l[PW-1:8];
  assign out_right = prod_r[PW-1:8];

endmodule

// File: rtl/line_audio_fifo_chk.sv
module line_audio_fifo_chk #(
  parameter int AW    = 16,
  parameter int VOL_W = 9,
  localparam int OUT_W = VOL_W + 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_stb,
  input logic [AW-1:0]    cfg_start,
  input logic [AW-1:0]    cfg_limit,
  input logic [AW-1:0]    cfg_tail_addr,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [31:0]      mem_wdata,
  input logic [AW-1:0]    tail_ptr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_left,
  input logic [OUT_W-1:0] out_right
);

  logic [1:0] reads_in_line;
  always_ff @(posedge clk) begin
    if (!rst_n) reads_in_line <= '0;
    else if (line_stb) reads_in_line <= '0;
    else if (mem_req && !mem_we && reads_in_line != 2'd3) reads_in_line <= reads_in_line + 2'd1;
  end

  assert_line_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reads_in_line <= 2'd2);

  assert_zero_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_req && mem_we && mem_wdata == 32'd0 && mem_addr == $past(mem_addr)));

  assert_tail_publish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr != cfg_tail_addr) |=>
      (mem_req && mem_we && mem_addr == cfg_tail_addr && mem_wdata == {{(32-AW){1'b0}}, tail_ptr}));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_ptr != $past(tail_ptr)) |->
      (($past(tail_ptr) == cfg_limit) ? (tail_ptr == cfg_start) : (tail_ptr == $past(tail_ptr) + AW'(1))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  assert_quiet_while_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req);

endmodule

bind line_audio_fifo line_audio_fifo_chk #(.AW(AW), .VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .cfg_start(cfg_start),
  .cfg_limit(cfg_limit), .cfg_tail_addr(cfg_tail_addr), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tail_ptr(tail_ptr),
  .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right));

// File: tb/line_audio_fifo_test.sv
module line_audio_fifo_test;
  localparam int AW = 16, ACC_W = 32, VOL_W = 9, OUT_W = VOL_W + 9;
  localparam int START = 16, LIMIT = 23, TAIL = 100;

  logic clk = 0, rst_n = 0, line_stb = 0, out_ready = 1;
  logic [AW-1:0] cfg_start = AW'(START), cfg_limit = AW'(LIMIT), cfg_tail_addr = AW'(TAIL);
  logic [ACC_W-1:0] cfg_line_inc = 0, cfg_sample_dec = 4;
  logic [VOL_W-1:0] cfg_vol_l = 256, cfg_vol_r = 256;
  logic mem_req, mem_we, out_valid;
  logic [AW-1:0] mem_addr, tail_ptr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [OUT_W-1:0] out_left, out_right;

  always #10 clk = ~clk;

  line_audio_fifo #(.AW(AW), .ACC_W(ACC_W), .VOL_W(VOL_W)) uut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .cfg_start(cfg_start), .cfg_limit(cfg_limit),
    .cfg_tail_addr(cfg_tail_addr), .cfg_line_inc(cfg_line_inc), .cfg_sample_dec(cfg_sample_dec),
    .cfg_vol_l(cfg_vol_l), .cfg_vol_r(cfg_vol_r), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tail_ptr(tail_ptr),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right));

  logic [31:0] mem [256];
  logic [31:0] mem_m [256];
  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[7:0]];
    end

  int q_l[$], q_r[$];
  always @(negedge clk)
    if (out_valid && out_ready) begin
      q_l.push_back(int'($signed(out_left)));
      q_r.push_back(int'($signed(out_right)));
    end

  int checks = 0, fails = 0;
  int acc_m = 0, ptr_m = START;
  int exp_n, exp_l[2], exp_r[2], rd_addr[2], ptr_after[2];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_word(int a, logic [31:0] v);
    mem[a] = v; mem_m[a] = v;
  endtask

  task automatic model_line();
    exp_n = 0;
    acc_m += int'(cfg_line_inc);
    while (acc_m >= 0 && exp_n < 2) begin
      logic [31:0] w;
      int sl, sr;
      w = mem_m[ptr_m];
      rd_addr[exp_n] = ptr_m;
      sl = $signed(w[31:16]); sr = $signed(w[15:0]);
      exp_l[exp_n] = (sl * int'(cfg_vol_l)) >>> 8;
      exp_r[exp_n] = (sr * int'(cfg_vol_r)) >>> 8;
      mem_m[ptr_m] = 32'd0;
      ptr_m = (ptr_m == LIMIT) ? START : ptr_m + 1;
      ptr_after[exp_n] = ptr_m;
      acc_m -= int'(cfg_sample_dec);
      exp_n++;
    end
  endtask

  task automatic strobe();
    @(posedge clk); #2 line_stb = 1;
    @(posedge clk); #2 line_stb = 0;
  endtask

  task automatic verify_line(string req);
    int bad = 0;
    @(negedge clk);
    check({req, " sample count"}, q_l.size(), exp_n);
    for (int i = 0; i < exp_n && i < q_l.size(); i++) begin
      check({req, " left value R4 R8"}, q_l[i], exp_l[i]);
      check({req, " right value R4 R8"}, q_r[i], exp_r[i]);
    end
    check({req, " tail_ptr R6 R7"}, int'(tail_ptr), ptr_m);
    if (exp_n > 0) check({req, " tail word in memory R7"}, int'(mem[TAIL]), ptr_m);
    for (int a = START; a <= LIMIT; a++) if (mem[a] !== mem_m[a]) bad++;
    check({req, " ring contents cleared R5"}, bad, 0);
    q_l.delete(); q_r.delete();
  endtask

  task automatic run_line(string req, int inc);
    cfg_line_inc = ACC_W'(inc);
    model_line();
    strobe();
    repeat (30) @(posedge clk);
    verify_line(req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 mem_req after reset", int'(mem_req), 0);
    check("R1 tail_ptr after reset", int'(tail_ptr), START);
  endtask

  task automatic t_pace();
    cfg_sample_dec = 4;
    run_line("R2 line1", 1);  check("R2 line1 count", exp_n, 1);
    run_line("R2 line2", 1);  check("R2 line2 count", exp_n, 0);
    run_line("R2 line3", 1);  check("R2 line3 count", exp_n, 0);
    run_line("R2 line4", 1);  check("R2 line4 count", exp_n, 1);
  endtask

  task automatic t_cap();
    run_line("R3 cap big inc", 20); check("R3 capped at two", exp_n, 2);
    run_line("R3 residue", 0);      check("R3 residue gives two", exp_n, 2);
    run_line("R3 residue end", 0);  check("R3 residue last", exp_n, 1);
  endtask

  task automatic t_wrap();
    check("R6 pointer on limit before wrap", int'(tail_ptr), LIMIT);
    run_line("R6 wrap", 4);
    check("R6 wrapped to start", int'(tail_ptr), START);
  endtask

  task automatic t_format();
    set_word(16, 32'h8000_7FFF);
    set_word(17, 32'hFFFD_0003);
    cfg_vol_l = 9'h1FF; cfg_vol_r = 9'd128;
    model_line_wrapper();
  endtask

  task automatic model_line_wrapper();
    cfg_line_inc = 8;
    model_line();
    strobe();
    repeat (30) @(posedge clk);
    @(negedge clk);
    if (q_l.size() == 2) begin
      check("R8 left full-scale negative", q_l[0], -65408);
      check("R8 right positive half gain", q_r[0], 16383);
      check("R8 left floor rounding", q_l[1], -6);
      check("R4 right small positive", q_r[1], 1);
    end
    verify_line("R4 R8 format");
  endtask

  task automatic t_backpressure();
    int held;
    for (int a = START; a <= LIMIT; a++) set_word(a, {16'(a * 300), 16'(-a * 11)});
    cfg_vol_l = 256; cfg_vol_r = 200;
    out_ready = 0;
    cfg_line_inc = 100;
    model_line();
    strobe();
    repeat (15) @(posedge clk);
    @(negedge clk);
    check("R9 valid held", int'(out_valid), 1);
    check("R9 first sample presented", int'($signed(out_left)), exp_l[0]);
    check("R9 only one read so far", int'(tail_ptr), ptr_after[0]);
    check("R9 second slot untouched", int'(mem[rd_addr[1]] != 32'd0), 1);
    held = int'($signed(out_right));
    @(posedge clk); #2 cfg_vol_l = 9'd7; cfg_vol_r = 9'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 left unchanged by config", int'($signed(out_left)), exp_l[0]);
    check("R10 right unchanged by config", int'($signed(out_right)), held);
    @(posedge clk); #2 out_ready = 1;
    repeat (30) @(posedge clk);
    verify_line("R9 R10 release");
    cfg_vol_l = 256; cfg_vol_r = 256;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin mem[a] = 32'd0; mem_m[a] = 32'd0; end
    for (int a = START; a <= LIMIT; a++) set_word(a, {16'(a * 1000 + 1), 16'(-(a * 77 + 5))});
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_pace();
    t_cap();
    t_wrap();
    t_format();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule